// File: doc/BRIEF.md
# Dual-Output Fractional-Clock PWM Slice

The slice produces two pulse-width-modulated outputs from one 16-bit counter. A fractional clock divider sets the counter's pace. Its divisor is a fixed-point value with 8 integer bits and 4 fraction bits. The counter either wraps to zero after its top value, or, in phase-correct mode, climbs to the top value and falls back to zero. Each output is high while the counter is below its own compare value. Each output can be inverted.

Software reaches the slice through a flat register port. A write takes effect at the clock edge. A read returns data combinationally. While the slice runs, software can push the counter one count ahead or one count behind. It can also read or overwrite the counter at any time. Compare and top writes go to a shadow copy. The copy in use reloads only at a period boundary, or at any time while the slice is disabled. Every period boundary sets a raw interrupt flag. A masked and forced interrupt line is presented on `irq_o`.

Register addresses on `addr_i`:
- 0: control
- 1: divisor
- 2: counter
- 3: compares
- 4: top
- 5: raw interrupt
- 6: interrupt enable
- 7: interrupt force

Top module: `pwm_slice`

## Requirements
- R1: After reset, the registers read as follows: control 0, divisor 0x010 (integer 1, fraction 0), counter 0, compares 0, top 0xFFFF, and all three interrupt registers 0. Both outputs and `irq_o` are low.
- R2: The divisor register holds the fraction in bits [3:0] and the integer in bits [11:4]. Let the effective divisor D be the register value in sixteenths, with an integer part of 0 counting as 256. Then K enabled clocks give floor(16*K/D) counter steps.
- R3: Control bit 0 enables the slice. With phase-correct mode off, a step taken at a count greater than or equal to top loads 0. Otherwise a step adds 1.
- R4: Control bit 1 selects phase-correct mode. In this mode, starting from 0 after enable, the counter runs 0..top..0. A step at top turns it downward, and a step at 0 turns it upward.
- R5: Output A is (counter < compare A) XOR control bit 2. Output B is (counter < compare B) XOR control bit 3. Compare A sits in bits [15:0] of register 3 and compare B in bits [31:16].
- R6: While the slice is enabled, compare and top writes reach the outputs only at the next period boundary. While it is disabled, they reach the outputs at once.
- R7: A counter write loads the counter at that edge, whether the slice is running or stopped, and the value reads back.
- R8: Control bit 7 (advance) takes effect only while the slice is enabled. At the next clock without a divider tick, it adds one extra step and then reads back 0.
- R9: Control bit 6 (retard) takes effect only while the slice is enabled. It cancels the next divider tick's step and then reads back 0.
- R10: A period boundary sets raw interrupt bit 0. That is a wrap in up mode, or the turn at 0 in phase-correct mode. Writing 1 to bit 0 of register 5 clears it, and a boundary in the same cycle wins.
- R11: `irq_o` = (raw AND enable) OR force, using bit 0 of registers 5, 6 and 7.
- R12: Control bits [5:4] are stored and read back. They have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| irq_o | output | 1 | Masked and forced interrupt |

## Verification
- **Write timing.** A register write lands at the edge on which it is captured. The outputs and `irq_o` follow combinationally from the registers. The bench therefore samples them at the falling edge just after the write.
- **Counter timing.** The counter steps on the same edge as the divider tick that causes it. After an enable write, the slice counts every edge up to and including the edge that captures the disable write. Each expected count is computed as floor(16*K/D), as K mod (top+1), or from the triangle sequence, with K equal to that edge count.
- **Advance and retard.** These requests are placed well before the first divider tick. Their one-count offset therefore lands at a known edge.
- **Shadow reload.** The deferred compare load is checked twice: once right after the write, and again after enough slow ticks for one wrap.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TOP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IRAW = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;
  localparam logic [ADDR_W-1:0] A_IFRC = 3'd7;

  // bit order is software visible
  typedef struct packed {
    logic       adv;
    logic       ret;
    logic [1:0] mode;
    logic       inv_b;
    logic       inv_a;
    logic       pc;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  localparam int ACC_W = INT_W + FRAC_W + 1;
  localparam int ONE_I = 1 << FRAC_W;
  localparam logic [ACC_W:0] ONE = ONE_I[ACC_W:0];

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   eff, sum;

  // integer part 0 stands for 2**INT_W
  assign eff    = {1'b0, (int_i == '0), int_i, frac_i};
  assign sum    = {1'b0, acc_q} + ONE;
  assign tick_o = en_i && (sum >= eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!en_i)  acc_q <= '0;
    else if (tick_o) acc_q <= ACC_W'(sum - eff);
    else             acc_q <= ACC_W'(sum);
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && eff >= (ONE << 1) && {1'b0, acc_q} < eff) |=> (!tick_o || eff != $past(eff))); // R2
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pc_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d, wrap;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    wrap   = 1'b0;
    if (!en_i) begin
      down_d = 1'b0;
    end else if (step_i) begin
      if (!pc_i) begin
        if (cnt_q >= top_i) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (!down_q) begin
        if (cnt_q >= top_i) begin
          down_d = 1'b1;
          cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          down_d = 1'b0;
          wrap   = 1'b1;
          cnt_d  = (top_i != '0) ? CNT_W'(1) : '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    if (ld_i) cnt_d = ld_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap && !ld_i;

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pc_i && step_i && !ld_i && cnt_q >= top_i) |=> (cnt_q == '0)); // R3
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pc_i && step_i && !ld_i && top_i != '0 && cnt_q <= top_i)
    |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R4
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2
) (
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  cmp_i,
  input  logic [N_CH-1:0]             inv_i,
  output logic [N_CH-1:0]             out_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign out_o[g] = (cnt_i < cmp_i[g]) ^ inv_i[g];
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_INT_W  = 8,
  parameter int DIV_FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              irq_o
);
  localparam int N_CH  = 2;
  localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;
  localparam logic [DIV_INT_W-1:0] INT_RST = DIV_INT_W'(1);

  ctrl_t                         ctrl_q;
  logic [DIV_INT_W-1:0]          div_int_q;
  logic [DIV_FRAC_W-1:0]         div_frac_q;
  logic [N_CH-1:0][CNT_W-1:0]    cmp_sh_q, cmp_act_q;
  logic [CNT_W-1:0]              top_sh_q, top_act_q;
  logic                          iraw_q, ien_q, ifrc_q;
  logic [CNT_W-1:0]              cnt;
  logic                          tick, step, wrap, ld_act;
  logic                          wr_ctrl, wr_div, wr_cnt, wr_cmp, wr_top;
  logic                          wr_iraw, wr_ien, wr_ifrc;
  logic [N_CH-1:0]               pwm;
  ctrl_t                         ctrl_w;

  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_div  = wr_en_i && addr_i == A_DIV;
  assign wr_cnt  = wr_en_i && addr_i == A_CNT;
  assign wr_cmp  = wr_en_i && addr_i == A_CMP;
  assign wr_top  = wr_en_i && addr_i == A_TOP;
  assign wr_iraw = wr_en_i && addr_i == A_IRAW;
  assign wr_ien  = wr_en_i && addr_i == A_IEN;
  assign wr_ifrc = wr_en_i && addr_i == A_IFRC;
  assign ctrl_w  = ctrl_t'(wdata_i[CTRL_W-1:0]);

  pwm_frac_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.en),
    .int_i  (div_int_q),
    .frac_i (div_frac_q),
    .tick_o (tick)
  );

  // retard swallows a tick; advance fills an idle clock
  assign step = (tick && !ctrl_q.ret) || (ctrl_q.adv && !tick);

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q.en),
    .pc_i     (ctrl_q.pc),
    .step_i   (step),
    .top_i    (top_act_q),
    .ld_i     (wr_cnt),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  pwm_compare #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cmp (
    .cnt_i (cnt),
    .cmp_i (cmp_act_q),
    .inv_i ({ctrl_q.inv_b, ctrl_q.inv_a}),
    .out_o (pwm)
  );

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];
  assign irq_o   = (iraw_q && ien_q) || ifrc_q;
  assign ld_act  = !ctrl_q.en || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q     <= ctrl_w;
      ctrl_q.adv <= ctrl_w.adv && ctrl_w.en;
      ctrl_q.ret <= ctrl_w.ret && ctrl_w.en;
    end else begin
      if (ctrl_q.adv && !tick) ctrl_q.adv <= 1'b0;
      if (ctrl_q.ret && tick)  ctrl_q.ret <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_int_q  <= INT_RST;
      div_frac_q <= '0;
      cmp_sh_q   <= '0;
      top_sh_q   <= '1;
    end else begin
      if (wr_div) {div_int_q, div_frac_q} <= wdata_i[DIV_W-1:0];
      if (wr_cmp) cmp_sh_q <= wdata_i[N_CH*CNT_W-1:0];
      if (wr_top) top_sh_q <= wdata_i[CNT_W-1:0];
    end
  end

  // active copies reload at a period boundary or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_act_q <= '0;
      top_act_q <= '1;
    end else if (ld_act) begin
      cmp_act_q <= cmp_sh_q;
      top_act_q <= top_sh_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iraw_q <= 1'b0;
      ien_q  <= 1'b0;
      ifrc_q <= 1'b0;
    end else begin
      if (wrap)                       iraw_q <= 1'b1;
      else if (wr_iraw && wdata_i[0]) iraw_q <= 1'b0;
      if (wr_ien)  ien_q  <= wdata_i[0];
      if (wr_ifrc) ifrc_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0]      = ctrl_q;
      A_DIV:   rdata_o[DIV_W-1:0]       = {div_int_q, div_frac_q};
      A_CNT:   rdata_o[CNT_W-1:0]       = cnt;
      A_CMP:   rdata_o[N_CH*CNT_W-1:0]  = cmp_sh_q;
      A_TOP:   rdata_o[CNT_W-1:0]       = top_sh_q;
      A_IRAW:  rdata_o[0]               = iraw_q;
      A_IEN:   rdata_o[0]               = ien_q;
      default: rdata_o[0]               = ifrc_q;
    endcase
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !wrap) |=> ($stable(cmp_act_q) && $stable(top_act_q))); // R6
  AST_ADV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.adv && !tick && !wr_ctrl) |=> !ctrl_q.adv); // R8
  AST_RET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ret && tick && !wr_ctrl && !wr_cnt) |=> (!ctrl_q.ret && $stable(cnt))); // R9
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> iraw_q); // R10
endmodule

// File: tb/sim_pwm_slice.sv
`timescale 1ns/1ps
module sim_pwm_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pa, pb, irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pwm_slice u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_a_o(pa), .pwm_b_o(pb), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; consumes exactly one rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int eff, exp_c;
    int divs[6] = '{32'h010, 32'h020, 32'h018, 32'h035, 32'h000, 32'h0FF};
    int ks[4]   = '{5, 10, 23, 37};

    idle(3);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 div", v, 32'h10);
    rd(2, v); chk("R1 cnt", v, 0);
    rd(3, v); chk("R1 cmp", v, 0);
    rd(4, v); chk("R1 top", v, 32'hFFFF);
    rd(5, v); chk("R1 iraw", v, 0);
    rd(6, v); chk("R1 ien", v, 0);
    rd(7, v); chk("R1 ifrc", v, 0);
    chk("R1 outs", {29'b0, pa, pb, irq}, 0);

    // R2 divider sweep, K = 600 enabled edges; R12 mode bits on the first case
    foreach (divs[i]) begin
      wr(2, 0);
      wr(1, divs[i]);
      wr(0, (i == 0) ? 32'h31 : 32'h01);
      if (i == 0) begin
        rd(0, v); chk("R12 mode readback", v, 32'h31);
      end
      idle(599);
      wr(0, 0);
      eff = ((divs[i] >> 4) == 0) ? 4096 + (divs[i] & 15) : divs[i];
      rd(2, v); chk("R2 tick count", v, (16 * 600) / eff);
    end

    // R3 up-count wrap, top = 9 loaded while stopped
    wr(1, 32'h10);
    wr(4, 9);
    foreach (ks[i]) begin
      wr(2, 0);
      wr(0, 1);
      idle(ks[i] - 1);
      wr(0, 0);
      rd(2, v); chk("R3 wrap count", v, ks[i] % 10);
    end
    // R10 raw flag set by wraps above
    rd(5, v); chk("R10 raw set", v, 1);
    // R11 masked
    chk("R11 masked", {31'b0, irq}, 0);
    wr(6, 1); chk("R11 enabled", {31'b0, irq}, 1);
    wr(5, 1); rd(5, v); chk("R10 w1c", v, 0);
    chk("R11 after clear", {31'b0, irq}, 0);
    wr(7, 1); chk("R11 force", {31'b0, irq}, 1);
    wr(7, 0); wr(6, 0);

    wr(4, 0);
    wr(2, 0); wr(0, 1); idle(6); wr(0, 0);
    rd(2, v); chk("R3 top zero", v, 0);

    // R4 phase-correct triangle, top = 4
    wr(4, 4);
    for (int k = 1; k <= 12; k++) begin
      wr(2, 0);
      wr(0, 3);
      idle(k - 1);
      wr(0, 0);
      exp_c = ((k % 8) <= 4) ? (k % 8) : 8 - (k % 8);
      rd(2, v); chk("R4 triangle", v, exp_c);
    end
    rd(5, v); chk("R10 pc boundary", v, 1);
    wr(5, 1);

    // R5 output sweep while stopped: A = 3, B = 7
    wr(4, 9);
    wr(3, (7 << 16) | 3);
    for (int inv = 0; inv < 4; inv++) begin
      wr(0, inv << 2);
      for (int c = 0; c < 12; c++) begin
        wr(2, c);
        chk("R5 out A", {31'b0, pa}, ((c < 3) ? 1 : 0) ^ (inv & 1));
        chk("R5 out B", {31'b0, pb}, ((c < 7) ? 1 : 0) ^ ((inv >> 1) & 1));
      end
    end

    // R6 deferred compare load; slow divider (16 clocks per tick), top = 3
    wr(0, 0);
    wr(1, 32'h100);
    wr(4, 3);
    wr(3, 3);
    wr(2, 0);
    wr(0, 1);
    wr(3, 0);
    chk("R6 held before wrap", {31'b0, pa}, 1);
    rd(3, v); chk("R6 shadow readback", v, 0);
    idle(100);
    chk("R6 applied after wrap", {31'b0, pa}, 0);
    // R7 direct load while running
    wr(2, 2);
    rd(2, v); chk("R7 counter load", v, 2);
    wr(0, 0);

    // R8 advance and R9 retard, top = 0xFFFF, 52 enabled edges
    wr(4, 32'hFFFF);
    wr(2, 0);
    wr(0, 1);
    wr(0, 32'h81);
    idle(50);
    rd(0, v); chk("R8 adv self-clear", v, 1);
    wr(0, 0);
    rd(2, v); chk("R8 advance", v, 52 / 16 + 1);

    wr(2, 0);
    wr(0, 1);
    wr(0, 32'h41);
    idle(50);
    rd(0, v); chk("R9 ret self-clear", v, 1);
    wr(0, 0);
    rd(2, v); chk("R9 retard", v, 52 / 16 - 1);

    // R8 request while stopped is dropped
    wr(2, 5);
    wr(0, 32'h80);
    idle(3);
    rd(0, v); chk("R8 stopped ignored", v, 0);
    rd(2, v); chk("R8 stopped count", v, 5);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule